// File: doc/BRIEF.md
# Cross-Core Prefetch Confidence Controller

In a chip with several cores, a miss that one core takes in both its data TLB and its prefetch buffer often comes before the same miss on other cores. This block decides which of those other cores should receive a copy of the resolved translation. The core that missed acts as the leader, and every other core is a possible follower. The block keeps one small saturating confidence counter for each ordered (leader, follower) pair. A leader pushes to a follower only while that pair's counter sits in its upper half.

Followers report back on the prefetches they receive. A hit in a follower's prefetch buffer on an entry pushed by some leader raises that leader's counter for the follower. An entry that leaves the follower's buffer without ever being used lowers it. The push decision is combinational from the leader's miss strobe and the stored counter value. Any feedback that arrives in the same cycle takes effect on the next clock edge.

Top module: `xcore_push_ctrl`

## Requirements
- R1: After reset every off-diagonal counter holds 2^(B-1). With all miss strobes high, every off-diagonal bit of the push mask is 1.
- R2: Bit L*N+F of `push_mask` is 1 exactly when `miss_vld[L]` is 1, L differs from F, and the (L,F) counter is at least 2^(B-1).
- R3: The diagonal bits of `push_mask` (L equal to F) are always 0.
- R4: A good report from follower F naming leader L raises counter (L,F) by one on the next edge. The counter stays at 2^B-1 once it gets there.
- R5: A bad report from follower F naming leader L lowers counter (L,F) by one on the next edge. The counter stays at 0 once it gets there.
- R6: When a good report and a bad report reach the same counter in one cycle, the increment is applied first (saturating) and then the decrement (saturating). A counter at 2^B-1 therefore ends at 2^B-2.
- R7: The push mask in a cycle uses the counter value held before that cycle's feedback is applied.
- R8: A report whose leader field equals the reporting follower's own index changes no counter.
- R9: A report changes only the counter of its own (leader, follower) pair.
- R10: A leader whose miss strobe is low drives 0 on its whole row of the push mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_vld | input | N_CORES | Bit L: core L missed in both its TLB and its prefetch buffer this cycle |
| good_vld | input | N_CORES | Bit F: follower F hit on a pushed entry this cycle |
| good_src | input | N_CORES*IDW | Field F (bits F*IDW+:IDW): leader that pushed the entry follower F used |
| bad_vld | input | N_CORES | Bit F: follower F evicted an unused pushed entry this cycle |
| bad_src | input | N_CORES*IDW | Field F: leader that pushed the entry follower F evicted |
| push_mask | output | N_CORES*N_CORES | Bit L*N+F: leader L pushes its translation to follower F this cycle |

## Verification
The bench drives each counter to both saturation limits and past them. A design that wraps instead of saturating would turn pushing back on after repeated bad reports, or turn it off after repeated good ones. It sends simultaneous good and bad reports to a counter already at the top. A design that applies the decrement first would leave that counter at its maximum instead of one below it. It also sends feedback in the same cycle as a miss, to catch a push decision taken from the updated value. A long pseudo-random sweep with self-addressed reports mixed in catches feedback routed to the wrong pair and self-reports that alter a counter.

// File: rtl/xcp_pkg.sv
package xcp_pkg;

    // Feedback arriving at one counter in one cycle, {inc, dec}
    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_DEC  = 2'b01,
        EV_INC  = 2'b10,
        EV_BOTH = 2'b11
    } ctr_event_e;

endpackage

// File: rtl/xcp_fb_decode.sv
module xcp_fb_decode #(
    parameter int N_CORES = 4,
    parameter int IDW     = 2,
    parameter int SELF    = 0
) (
    input  logic               vld,
    input  logic [IDW-1:0]     src,
    output logic [N_CORES-1:0] hit
);

    // One-hot leader select; a report naming the reporter itself is dropped
    always_comb begin
        hit = '0;
        for (int l = 0; l < N_CORES; l++) begin
            if (vld && (int'(src) == l) && (l != SELF)) begin
                hit[l] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xcp_conf_ctr.sv
module xcp_conf_ctr
    import xcp_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic push_ok
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_HALF = {1'b1, {(CNT_W-1){1'b0}}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t state_d, state_q;
    ctr_event_e ev;
    logic [CNT_W-1:0] after_inc;

    always_comb begin
        ev        = ctr_event_e'({inc, dec});
        state_d   = state_q;
        after_inc = (state_q.cnt == CNT_MAX) ? CNT_MAX : state_q.cnt + CNT_ONE;
        unique case (ev)
            EV_INC:  state_d.cnt = after_inc;
            EV_DEC:  state_d.cnt = (state_q.cnt == CNT_ZERO) ? CNT_ZERO
                                                             : state_q.cnt - CNT_ONE;
            EV_BOTH: state_d.cnt = (after_inc == CNT_ZERO) ? CNT_ZERO
                                                           : after_inc - CNT_ONE;
            default: state_d.cnt = state_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.cnt <= CNT_HALF;
        end else begin
            state_q <= state_d;
        end
    end

    // Upper half of the range enables pushing
    assign push_ok = state_q.cnt[CNT_W-1];

    // R4
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.cnt == CNT_MAX && inc && !dec) |=> (state_q.cnt == CNT_MAX));

    // R5
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.cnt == CNT_ZERO && dec && !inc) |=> (state_q.cnt == CNT_ZERO));

    // R6
    inc_then_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.cnt == CNT_MAX && inc && dec) |=> (state_q.cnt == CNT_MAX - CNT_ONE));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !dec) |=> $stable(state_q.cnt));

endmodule

// File: rtl/xcore_push_ctrl.sv
module xcore_push_ctrl #(
    parameter int N_CORES = 4,
    parameter int CNT_W   = 2,
    localparam int IDW    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_CORES-1:0]           miss_vld,
    input  logic [N_CORES-1:0]           good_vld,
    input  logic [N_CORES*IDW-1:0]       good_src,
    input  logic [N_CORES-1:0]           bad_vld,
    input  logic [N_CORES*IDW-1:0]       bad_src,
    output logic [N_CORES*N_CORES-1:0]   push_mask
);

    // Indexed [follower][leader]
    logic [N_CORES-1:0] good_hit [N_CORES];
    logic [N_CORES-1:0] bad_hit  [N_CORES];

    for (genvar f = 0; f < N_CORES; f++) begin : g_fol
        xcp_fb_decode #(.N_CORES(N_CORES), .IDW(IDW), .SELF(f)) u_good_dec (
            .vld (good_vld[f]),
            .src (good_src[f*IDW +: IDW]),
            .hit (good_hit[f])
        );
        xcp_fb_decode #(.N_CORES(N_CORES), .IDW(IDW), .SELF(f)) u_bad_dec (
            .vld (bad_vld[f]),
            .src (bad_src[f*IDW +: IDW]),
            .hit (bad_hit[f])
        );
    end

    for (genvar l = 0; l < N_CORES; l++) begin : g_lead
        for (genvar f = 0; f < N_CORES; f++) begin : g_pair
            if (l == f) begin : g_diag
                assign push_mask[l*N_CORES + f] = 1'b0;
            end else begin : g_ctr
                logic push_ok;
                xcp_conf_ctr #(.CNT_W(CNT_W)) u_ctr (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .inc     (good_hit[f][l]),
                    .dec     (bad_hit[f][l]),
                    .push_ok (push_ok)
                );
                assign push_mask[l*N_CORES + f] = miss_vld[l] & push_ok;
            end
        end

        // R10
        idle_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !miss_vld[l] |-> ($countones(push_mask[l*N_CORES +: N_CORES]) == 0));
    end

endmodule

// File: tb/xcore_push_ctrl_tb.sv
module xcore_push_ctrl_tb;

    localparam int N          = 4;
    localparam int B          = 2;
    localparam int IDW        = 2;
    localparam int CLK_PERIOD = 10;
    localparam int CMAX       = (1 << B) - 1;
    localparam int CHALF      = 1 << (B - 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N-1:0]       miss_vld = '0;
    logic [N-1:0]       good_vld = '0;
    logic [N*IDW-1:0]   good_src = '0;
    logic [N-1:0]       bad_vld = '0;
    logic [N*IDW-1:0]   bad_src = '0;
    logic [N*N-1:0]     push_mask;

    int model [N][N];
    int n_chk  = 0;
    int n_fail = 0;

    xcore_push_ctrl #(.N_CORES(N), .CNT_W(B)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .miss_vld  (miss_vld),
        .good_vld  (good_vld),
        .good_src  (good_src),
        .bad_vld   (bad_vld),
        .bad_src   (bad_src),
        .push_mask (push_mask)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Source vector where follower f names leader l; all others name themselves
    function automatic logic [N*IDW-1:0] src_one(int f, int l);
        logic [N*IDW-1:0] v;
        for (int i = 0; i < N; i++) v[i*IDW +: IDW] = IDW'(i);
        v[f*IDW +: IDW] = IDW'(l);
        return v;
    endfunction

    task automatic check_mask(string tag);
        for (int l = 0; l < N; l++) begin
            for (int f = 0; f < N; f++) begin
                logic exp_b;
                string t;
                exp_b = (l != f) && miss_vld[l] && (model[l][f] >= CHALF);
                t = (l == f) ? "R3" : (!miss_vld[l] ? "R10" : tag);
                n_chk++;
                if (push_mask[l*N + f] !== exp_b) begin
                    n_fail++;
                    $display("FAIL %s: push_mask[L=%0d,F=%0d] actual %b expected %b",
                             t, l, f, push_mask[l*N + f], exp_b);
                end
            end
        end
    endtask

    task automatic step(input logic [N-1:0] m, input logic [N-1:0] gv,
                        input logic [N*IDW-1:0] gs, input logic [N-1:0] bv,
                        input logic [N*IDW-1:0] bs, input string tag);
        @(negedge clk);
        miss_vld = m; good_vld = gv; good_src = gs; bad_vld = bv; bad_src = bs;
        #1;
        check_mask(tag);
        @(posedge clk);
        for (int f = 0; f < N; f++) begin
            int gl;
            int bl;
            gl = int'(gs[f*IDW +: IDW]);
            bl = int'(bs[f*IDW +: IDW]);
            if (gv[f] && gl != f && model[gl][f] < CMAX) model[gl][f]++;
            if (bv[f] && bl != f && model[bl][f] > 0)    model[bl][f]--;
        end
    endtask

    initial begin
        logic [N*IDW-1:0] self_src;
        self_src = src_one(0, 0);
        for (int l = 0; l < N; l++)
            for (int f = 0; f < N; f++) model[l][f] = CHALF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        step('1, '0, self_src, '0, self_src, "R1");
        // bad report from 2 about leader 1 in the same cycle as leader 1 misses
        step(4'b0010, '0, self_src, 4'b0100, src_one(2, 1), "R7");
        step('1, '0, self_src, '0, self_src, "R5");
        step('1, '0, self_src, 4'b0100, src_one(2, 1), "R5");
        step('1, '0, self_src, 4'b0100, src_one(2, 1), "R5");
        step('1, 4'b0100, src_one(2, 1), '0, self_src, "R5");
        step('1, 4'b0100, src_one(2, 1), '0, self_src, "R4");
        for (int i = 0; i < 4; i++)
            step('1, 4'b0100, src_one(2, 1), '0, self_src, "R4");
        step('1, '0, self_src, 4'b0100, src_one(2, 1), "R4");
        step('1, '0, self_src, 4'b0100, src_one(2, 1), "R4");
        step('1, '0, self_src, '0, self_src, "R4");
        // counter (1,2) back to max, then good and bad together
        for (int i = 0; i < 3; i++)
            step('1, 4'b0100, src_one(2, 1), '0, self_src, "R6");
        step('1, 4'b0100, src_one(2, 1), 4'b0100, src_one(2, 1), "R6");
        step('1, '0, self_src, 4'b0100, src_one(2, 1), "R6");
        step('1, '0, self_src, '0, self_src, "R6");
        // self-addressed reports on every follower
        step('1, '1, self_src, '1, self_src, "R8");
        step('1, '1, self_src, '1, self_src, "R8");
        step('1, '0, self_src, '0, self_src, "R8");
        // one pair only: leader 3, follower 0
        step('1, '0, self_src, 4'b0001, src_one(0, 3), "R9");
        step('1, '0, self_src, '0, self_src, "R9");
        step('0, '0, self_src, '0, self_src, "R10");

        // pseudo-random sweep
        for (int i = 0; i < 4000; i++) begin
            logic [N*IDW-1:0] gs;
            logic [N*IDW-1:0] bs;
            gs = (N*IDW)'($urandom);
            bs = (N*IDW)'($urandom);
            step(N'($urandom), N'($urandom), gs, N'($urandom), bs, "R2");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog (R2): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule